// File: doc/BRIEF.md
# Guarded Pipelined Multiply-Accumulate Cell

This block is a small accelerator cell that runs the body of a conditional accumulate loop. Each iteration takes four signed 16-bit operands, `k_val`, `l_val`, `m_val` and `o_val`. A guard tests whether `o_val` equals one. If it does, the iteration's branch value is `k_val*l_val`. If it does not, a recurrence register is updated as `c = c*m_val + l_val`, and the new `c` becomes the branch value. The branch value is then multiplied by `o_val`, and the product is added into a running sum that drives `acc_out`. The loop counter lives outside the cell. The surrounding controller presents one operand set per slot and pulls `run_en` low to freeze the cell.

One multiplier and one adder are shared over a three-stage pipeline. Each slot lasts two cycles. Stage 0 forms the guarded product. Stage 1 forms the recurrence sum and selects the branch value. Stage 2 forms the weighted product and accumulates it. A value is carried only as far as its last consumer, through serial delay registers: `o_val` passes through two of them, and `l_val` and the guard through one each. The two branches never both execute, so they share one stage-0 result register and one stage-1 branch register.

The controller is a six-state machine. It counts pipeline fill and tracks the slot phase. The states are FILL0_A, FILL0_B (only stage 0 holds work), FILL1_A, FILL1_B (stages 0 and 1 hold work), and STEADY_A, STEADY_B (all stages hold work). When `run_en` is high, every state moves to the next one: FILL0_A→FILL0_B, FILL0_B→FILL1_A, FILL1_A→FILL1_B, FILL1_B→STEADY_A, STEADY_A→STEADY_B and STEADY_B→STEADY_A. When `run_en` is low, every state holds. Phase A runs the stage-1 sum and the stage-2 product. Phase B runs the stage-0 product and the accumulation, and it advances the delay chains.

Top module: `gpm_cell`

## Requirements
- R1: While `rst` is high, and after its release, the running sum and the recurrence value are zero, and the controller sits in FILL0_A.
- R2: Counting only the cycles with `run_en` high since reset, even-numbered cycles are phase A and odd-numbered cycles are phase B. Operands are taken only at the clock edge of a phase-B cycle; their values in phase-A cycles have no effect.
- R3: When the sampled `o_val` equals 1, the branch value is the low 16 bits of `k_val*l_val`, and the recurrence value is left unchanged.
- R4: When the sampled `o_val` is not 1, the recurrence value becomes the low 16 bits of `c*m_val + l_val`, where `c` is the value left by the most recent earlier iteration (zero after reset). The branch value is this new `c`.
- R5: Each iteration adds the low 16 bits of `o_val*branch` to the running sum, with the sum wrapping modulo 2^16.
- R6: An iteration sampled at active cycle n is visible on `acc_out` after the edge of active cycle n+4.
- R7: During start-up, the empty stages change neither `acc_out` nor the recurrence value. `acc_out` stays zero through the first five active cycles after reset.
- R8: A cycle with `run_en` low changes nothing. `acc_out`, the recurrence value and the controller state keep their values, and operand changes are ignored. Work resumes in the same phase when `run_en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| run_en | input | 1 | Enables the cell when high; stalls it when low |
| k_val | input | 16 | Signed multiplicand for the guarded branch |
| l_val | input | 16 | Signed operand used by both branches |
| m_val | input | 16 | Signed recurrence multiplier |
| o_val | input | 16 | Signed guard and weight operand |
| acc_out | output | 16 | Running sum, signed |

## Verification
An iteration sampled at the phase-B edge of active cycle n reaches `acc_out` after active cycle n+4, two slots later. The recurrence value it writes is already in place for the iteration sampled one slot later. The reference model in the bench counts only cycles with `run_en` high. It samples operands at the odd counts and queues the weighted products. Each product is released into the expected sum exactly two samples later. The expected sum is compared with `acc_out` at every falling edge, where the register outputs have settled. Fixed cases pin the start-up zeros and the first sums to hand-computed cycle counts.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

    // Pipeline geometry of the loop body
    localparam int STAGES      = 3;
    localparam int SLOT_CYCLES = 2;
    // Stage where o is captured and stage where it is last consumed
    localparam int STG_O_CAP   = 0;
    localparam int STG_O_USE   = STAGES - 1;
    localparam int O_LAT       = STG_O_USE - STG_O_CAP;
    localparam int L_LAT       = 1;

    typedef enum logic [2:0] {
        ST_FILL0_A  = 3'd0,
        ST_FILL0_B  = 3'd1,
        ST_FILL1_A  = 3'd2,
        ST_FILL1_B  = 3'd3,
        ST_STEADY_A = 3'd4,
        ST_STEADY_B = 3'd5
    } gpm_state_e;

    // Multiplier operand A sources
    typedef enum logic [1:0] {
        MA_K = 2'd0,
        MA_C = 2'd1,
        MA_O = 2'd2
    } mula_sel_e;

    // Multiplier operand B sources
    typedef enum logic [1:0] {
        MB_L   = 2'd0,
        MB_M   = 2'd1,
        MB_SEL = 2'd2
    } mulb_sel_e;

    typedef struct packed {
        mula_sel_e mula_sel;
        mulb_sel_e mulb_sel;
        logic      add_acc;   // 1: e + d, 0: b + l
        logic      en_ba;     // stage-0 product register
        logic      en_ac;     // stage-1 branch register
        logic      en_c;      // recurrence register
        logic      en_d;      // stage-2 product register
        logic      en_e;      // running sum
        logic      shift;     // advance delay chains
    } gpm_ctrl_t;

endpackage

// File: rtl/gpm_ctrl.sv
module gpm_ctrl
    import gpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       g1_now,
    input  logic       g1_s1,
    output gpm_state_e state,
    output gpm_ctrl_t  ctl
);

    gpm_state_e state_nx;

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_FILL0_A;
        else     state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        if (run_en) begin
            unique case (state)
                ST_FILL0_A:  state_nx = ST_FILL0_B;
                ST_FILL0_B:  state_nx = ST_FILL1_A;
                ST_FILL1_A:  state_nx = ST_FILL1_B;
                ST_FILL1_B:  state_nx = ST_STEADY_A;
                ST_STEADY_A: state_nx = ST_STEADY_B;
                ST_STEADY_B: state_nx = ST_STEADY_A;
                default:     state_nx = ST_FILL0_A;
            endcase
        end
    end

    // Control outputs
    always_comb begin
        ctl          = '0;
        ctl.mula_sel = MA_O;
        ctl.mulb_sel = MB_SEL;
        unique case (state)
            ST_FILL0_A: begin
                // stages 1 and 2 empty: no work in phase A
            end
            ST_FILL1_A: begin
                ctl.en_ac = run_en;
                ctl.en_c  = run_en & ~g1_s1;
            end
            ST_STEADY_A: begin
                ctl.en_ac = run_en;
                ctl.en_c  = run_en & ~g1_s1;
                ctl.en_d  = run_en;
            end
            ST_FILL0_B, ST_FILL1_B, ST_STEADY_B: begin
                ctl.mula_sel = g1_now ? MA_K : MA_C;
                ctl.mulb_sel = g1_now ? MB_L : MB_M;
                ctl.add_acc  = 1'b1;
                ctl.en_ba    = run_en;
                ctl.shift    = run_en;
                ctl.en_e     = run_en & (state == ST_STEADY_B);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/gpm_shift_chain.sv
module gpm_shift_chain #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   taps
);

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or posedge rst) begin
                if (rst)     taps <= '0;
                else if (en) taps[0] <= din;
            end
        end else begin : g_serial
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    taps <= '0;
                end else if (en) begin
                    taps[0] <= din;
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/gpm_opmux.sv
module gpm_opmux #(
    parameter int W = 16,
    parameter int N = 3,
    localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][W-1:0] din,
    input  logic [SEL_W-1:0]    sel,
    output logic [W-1:0]        dout
);

    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == SEL_W'(i)) dout = din[i];
        end
    end

endmodule

// File: rtl/gpm_datapath.sv
module gpm_datapath
    import gpm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  gpm_ctrl_t         ctl,
    input  logic [DATA_W-1:0] k_val,
    input  logic [DATA_W-1:0] l_val,
    input  logic [DATA_W-1:0] m_val,
    input  logic [DATA_W-1:0] o_val,
    output logic              g1_now,
    output logic              g1_s1,
    output logic [DATA_W-1:0] c_q,
    output logic [DATA_W-1:0] o_s1,
    output logic [DATA_W-1:0] acc_q
);

    logic [DATA_W-1:0] ba_q, ac_q, d_q;
    logic [DATA_W-1:0] o_s2, l_s1;
    logic [O_LAT-1:0][DATA_W-1:0] o_taps;
    logic [L_LAT-1:0][DATA_W-1:0] l_taps;
    logic [0:0][0:0]              g_taps;
    logic [DATA_W-1:0] mul_a, mul_b, prod, add_a, add_b, sum;

    assign g1_now = (o_val == DATA_W'(1));

    // Serial delay chains
    gpm_shift_chain #(.W(DATA_W), .DEPTH(O_LAT)) u_o_chain (
        .clk(clk), .rst(rst), .en(ctl.shift), .din(o_val), .taps(o_taps));
    gpm_shift_chain #(.W(DATA_W), .DEPTH(L_LAT)) u_l_chain (
        .clk(clk), .rst(rst), .en(ctl.shift), .din(l_val), .taps(l_taps));
    gpm_shift_chain #(.W(1), .DEPTH(1)) u_g_chain (
        .clk(clk), .rst(rst), .en(ctl.shift), .din(g1_now), .taps(g_taps));

    assign o_s1  = o_taps[0];
    assign o_s2  = o_taps[O_LAT-1];
    assign l_s1  = l_taps[L_LAT-1];
    assign g1_s1 = g_taps[0][0];

    // Shared multiplier with operand multiplexers
    gpm_opmux #(.W(DATA_W), .N(3)) u_mula (
        .din({o_s2, c_q, k_val}), .sel(ctl.mula_sel), .dout(mul_a));
    gpm_opmux #(.W(DATA_W), .N(3)) u_mulb (
        .din({ac_q, m_val, l_val}), .sel(ctl.mulb_sel), .dout(mul_b));
    assign prod = mul_a * mul_b;

    // Shared adder with operand multiplexers
    gpm_opmux #(.W(DATA_W), .N(2)) u_adda (
        .din({acc_q, ba_q}), .sel(ctl.add_acc), .dout(add_a));
    gpm_opmux #(.W(DATA_W), .N(2)) u_addb (
        .din({d_q, l_s1}), .sel(ctl.add_acc), .dout(add_b));
    assign sum = add_a + add_b;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ba_q  <= '0;
            ac_q  <= '0;
            c_q   <= '0;
            d_q   <= '0;
            acc_q <= '0;
        end else begin
            if (ctl.en_ba) ba_q  <= prod;
            if (ctl.en_ac) ac_q  <= g1_s1 ? ba_q : sum;
            if (ctl.en_c)  c_q   <= sum;
            if (ctl.en_d)  d_q   <= prod;
            if (ctl.en_e)  acc_q <= sum;
        end
    end

endmodule

// File: rtl/gpm_cell.sv
module gpm_cell
    import gpm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_en,
    input  logic signed [DATA_W-1:0] k_val,
    input  logic signed [DATA_W-1:0] l_val,
    input  logic signed [DATA_W-1:0] m_val,
    input  logic signed [DATA_W-1:0] o_val,
    output logic signed [DATA_W-1:0] acc_out
);

    gpm_state_e        state;
    gpm_ctrl_t         ctl;
    logic              g1_now, g1_s1;
    logic [DATA_W-1:0] c_q, o_s1, acc_q;

    gpm_ctrl u_ctrl (
        .clk(clk), .rst(rst), .run_en(run_en),
        .g1_now(g1_now), .g1_s1(g1_s1),
        .state(state), .ctl(ctl));

    gpm_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst(rst), .ctl(ctl),
        .k_val(k_val), .l_val(l_val), .m_val(m_val), .o_val(o_val),
        .g1_now(g1_now), .g1_s1(g1_s1), .c_q(c_q), .o_s1(o_s1),
        .acc_q(acc_q));

    assign acc_out = acc_q;

endmodule

// File: rtl/gpm_cell_chk.sv
module gpm_cell_chk
    import gpm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              run_en,
    input logic [DATA_W-1:0] o_val,
    input logic [DATA_W-1:0] acc_out,
    input gpm_state_e        state,
    input logic [DATA_W-1:0] c_q,
    input logic [DATA_W-1:0] o_s1,
    input logic              g1_s1
);

    logic ph_a, ph_b;
    assign ph_a = (state == ST_FILL0_A) || (state == ST_FILL1_A) || (state == ST_STEADY_A);
    assign ph_b = (state == ST_FILL0_B) || (state == ST_FILL1_B) || (state == ST_STEADY_B);

    // R2: an active phase-A cycle is followed by phase B
    p_phase_alt_r2: assert property (@(posedge clk) disable iff (rst)
        (run_en && ph_a) |=> ph_b);

    // R8: a stalled cycle keeps the sum and the controller state
    p_stall_acc_r8: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(acc_out));
    p_stall_state_r8: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(state));

    // R7: the sum moves only at an active steady-state phase-B edge
    p_acc_steady_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_out) |-> $past(run_en && state == ST_STEADY_B));

    // R4: the recurrence moves only for an unguarded iteration in stage 1
    p_c_g2_only_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(c_q) |-> $past(run_en && ph_a && !g1_s1 && state != ST_FILL0_A));

    // R5: o enters its delay chain at the sampling edge
    p_o_chain_r5: assert property (@(posedge clk) disable iff (rst)
        (run_en && ph_b) |=> (o_s1 == $past(o_val)));

endmodule

bind gpm_cell gpm_cell_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .run_en(run_en), .o_val(o_val),
    .acc_out(acc_out), .state(state), .c_q(c_q), .o_s1(o_s1),
    .g1_s1(g1_s1));

// File: tb/gpm_cell_tb_top.sv
module gpm_cell_tb_top;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               run_en = 1'b0;
    logic signed [15:0] k_val = '0, l_val = '0, m_val = '0, o_val = '0;
    logic signed [15:0] acc_out;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_on = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int          act = 0;
    logic [15:0] m_e = '0, m_c = '0;
    logic [15:0] pend[$];

    gpm_cell dut_i (
        .clk(clk), .rst(rst), .run_en(run_en),
        .k_val(k_val), .l_val(l_val), .m_val(m_val), .o_val(o_val),
        .acc_out(acc_out));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [15:0] actv, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t",
                     req, $signed(actv), $signed(expv), $time);
        end
    endtask

    // Behavioural reference: counts active cycles, samples on odd ones,
    // releases each weighted product two samples later
    always @(posedge clk) begin
        logic [15:0] sel;
        if (rst) begin
            act = 0;
            m_e = '0;
            m_c = '0;
            pend.delete();
        end else if (run_en) begin
            if (act % 2 == 1) begin
                if (pend.size() == 2) m_e = m_e + pend.pop_front();
                if (o_val == 16'sd1) begin
                    sel = k_val * l_val;
                end else begin
                    m_c = m_c * m_val + l_val;
                    sel = m_c;
                end
                pend.push_back(o_val * sel);
            end
            act++;
        end
    end

    always @(negedge clk) begin
        if (!rst && cmp_on) check(acc_out == m_e, cur_req, acc_out, m_e);
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        check(acc_out == 16'd0, "R1", acc_out, 16'd0);
        rst = 1'b0;
    endtask

    task automatic set_ops(input logic [15:0] k, input logic [15:0] l,
                           input logic [15:0] m, input logic [15:0] o);
        k_val = k; l_val = l; m_val = m; o_val = o;
    endtask

    task automatic rand_ops();
        int pick = $urandom_range(0, 3);
        k_val = 16'($urandom);
        l_val = 16'($urandom);
        m_val = 16'($urandom_range(0, 7));
        o_val = (pick == 0) ? 16'd1 : (pick == 1) ? 16'($urandom) : 16'($urandom_range(0, 4));
    endtask

    initial begin
        logic [15:0] hold;
        // R1: reset state
        do_reset();
        cmp_on = 1'b1;
        @(negedge clk);
        check(acc_out == 16'd0, "R1", acc_out, 16'd0);

        // R7 / R6 / R3: constant guarded iterations, d = 1*(3*5) = 15
        do_reset();
        cur_req = "R7";
        set_ops(16'd3, 16'd5, 16'd0, 16'd1);
        run_en = 1'b1;
        repeat (5) @(negedge clk);
        check(acc_out == 16'd0, "R7", acc_out, 16'd0);
        @(negedge clk);
        check(acc_out == 16'd15, "R6", acc_out, 16'd15);
        repeat (2) @(negedge clk);
        check(acc_out == 16'd30, "R3", acc_out, 16'd30);

        // R4: recurrence c = 2c + 1 with weight 2 -> sums 2, 8, 22
        do_reset();
        cur_req = "R4";
        set_ops(16'd9, 16'd1, 16'd2, 16'd2);
        run_en = 1'b1;
        repeat (10) @(negedge clk);
        check(acc_out == 16'd22, "R4", acc_out, 16'd22);

        // R3: guarded product wraps: 300*300 mod 2^16 = 24464
        do_reset();
        cur_req = "R3";
        set_ops(16'd300, 16'd300, 16'd0, 16'd1);
        run_en = 1'b1;
        repeat (6) @(negedge clk);
        check(acc_out == 16'd24464, "R3", acc_out, 16'd24464);

        // R2: operands changed in phase A are ignored
        do_reset();
        cur_req = "R2";
        run_en = 1'b1;
        for (int i = 0; i < 400; i++) begin
            if (i % 2 == 0) rand_ops();
            else begin k_val = 16'($urandom); l_val = 16'($urandom); end
            @(negedge clk);
        end

        // R5: negative weights and wrapping sums
        cur_req = "R5";
        for (int i = 0; i < 400; i++) begin
            rand_ops();
            o_val = 16'($urandom) | 16'h8000;
            if (i % 5 == 0) o_val = 16'd1;
            @(negedge clk);
        end

        // R8: long stall with changing operands, then resume
        cur_req = "R8";
        @(negedge clk);
        run_en = 1'b0;
        hold = acc_out;
        for (int i = 0; i < 10; i++) begin
            rand_ops();
            @(negedge clk);
        end
        check(acc_out == hold, "R8", acc_out, hold);
        run_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            rand_ops();
            @(negedge clk);
        end

        // R8: random stalls in both phases
        for (int i = 0; i < 3000; i++) begin
            rand_ops();
            run_en = ($urandom_range(0, 3) != 0);
            @(negedge clk);
        end
        run_en = 1'b1;
        repeat (8) @(negedge clk);

        // R1: reset after activity clears the sum
        cur_req = "R1";
        do_reset();
        @(negedge clk);
        check(acc_out == 16'd0, "R1", acc_out, 16'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule